// File: doc/BRIEF.md
# Reverse Rotation Protection Monitor

This block supervises a three-phase brushless motor drive and shuts every power switch off when the rotor turns against the commanded direction for too long. It decodes the three digital Hall bits into one of six rotor positions. It then classifies each position change as a forward or a backward step, relative to a direction select input. Once the rotor has moved backward by more than 120 electrical degrees, the rotor is judged to be reversing.

The block does not cut the drive as soon as it judges reversal. While the drive is active, it counts strobes of a shared time base, the same period that the lock-protection timer uses. If reversal lasts for a full lock period, it latches a shutdown that forces all six outputs off. A rotor that is already turning backward when drive starts gets the same grace period. While the protection is enabled, a zero duty command also forces all outputs off.

The latched shutdown is released by a stop command held long enough, by a zero duty command held for the clearing period, or by reset. The protection is enabled by an active-low select input.

Top module: `reverse_guard`

## Requirements
- R1: While `prot_sel_n` is high, `kill_o` and `rev_o` stay low and all backward-step, timer and latch state is cleared.
- R2: The Hall code maps to a step index as follows: 101→0, 100→1, 110→2, 010→3, 011→4, 001→5. With `dir_i`=0, a change to index+1 (mod 6) is a forward step and a change to index−1 is a backward step. With `dir_i`=1, these two roles swap. A change of any other size counts as neither kind of step.
- R3: `rev_o` rises on the clock edge that registers the third consecutive backward step, and not before that step.
- R4: While `rev_o` is high and `drive_on_i` is high, each `tick_i` strobe advances a reverse timer. On the LOCK_TICKS-th such strobe, a shutdown latches and `kill_o` goes high. The timer restarts whenever the reversing or drive condition drops.
- R5: Reversing that begins while drive is off does not latch a shutdown. The lock period starts counting only when drive turns on.
- R6: While protection is enabled, `zero_duty_i` high forces `kill_o` high in the same cycle.
- R7: `stop_i` held high for STOP_CYCLES consecutive clocks clears the latch, the backward count and the timer. A shorter pulse clears nothing.
- R8: `zero_duty_i` held high across ZERO_TICKS strobes clears the latch, the backward count and the timer. After that, `kill_o` falls when zero duty is released.
- R9: A forward step resets the backward-step count and the reverse timer.
- R10: The codes 000 and 111 are ignored. They neither move the tracked position nor reset the backward count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| hall_i | input | 3 | Synchronized Hall bits, phase 1 in bit 2 |
| dir_i | input | 1 | Commanded direction select |
| prot_sel_n | input | 1 | Active-low protection enable |
| drive_on_i | input | 1 | Drive is running |
| zero_duty_i | input | 1 | Commanded duty is zero |
| stop_i | input | 1 | Stop command |
| tick_i | input | 1 | One-cycle strobe of the shared lock time base |
| rev_o | output | 1 | Reversal judged |
| kill_o | output | 1 | Force all six outputs off |

## Verification
On every cycle, the assertions check the following:
- A disabled monitor stays silent.
- One Hall change is never both forward and backward.
- An invalid code leaves the tracked position untouched.
- A forward step empties the backward count.
- A latch can only be set from a reversing, driven state.
- A clearing event drops the latch.

The exact length of the lock period, the grace period when drive starts on a reversing rotor, and the rule that a short stop leaves the latch alone involve counts over many strobes. Only the bench scenarios, compared each cycle against the reference model, can show these.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

    typedef struct packed {
        logic       vld;
        logic [2:0] idx;
    } hall_pos_t;

    function automatic hall_pos_t hall_to_pos(input logic [2:0] code);
        hall_pos_t p;
        p.vld = 1'b1;
        case (code)
            3'b101:  p.idx = 3'd0;
            3'b100:  p.idx = 3'd1;
            3'b110:  p.idx = 3'd2;
            3'b010:  p.idx = 3'd3;
            3'b011:  p.idx = 3'd4;
            3'b001:  p.idx = 3'd5;
            default: begin
                p.idx = 3'd0;
                p.vld = 1'b0;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rrp_hall_judge.sv
module rrp_hall_judge
    import rrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_i,
    output logic       fwd_o,
    output logic       back_o
);
    hall_pos_t cur;
    hall_pos_t last_q, last_d;
    logic [2:0] up_idx, dn_idx;
    logic       moved;

    always_comb begin
        cur    = hall_to_pos(hall_i);
        up_idx = (last_q.idx == 3'd5) ? 3'd0 : last_q.idx + 3'd1;
        dn_idx = (last_q.idx == 3'd0) ? 3'd5 : last_q.idx - 3'd1;
        moved  = cur.vld && last_q.vld && (cur.idx != last_q.idx);
        if (dir_i) begin
            fwd_o  = moved && (cur.idx == dn_idx);
            back_o = moved && (cur.idx == up_idx);
        end else begin
            fwd_o  = moved && (cur.idx == up_idx);
            back_o = moved && (cur.idx == dn_idx);
        end
        last_d = cur.vld ? cur : last_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= last_d;
    end

    AST_FWD_BACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_o && back_o)); // R2

    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cur.vld |=> $stable(last_q)); // R10

endmodule

// File: rtl/rrp_clear_ctl.sv
module rrp_clear_ctl #(
    parameter int STOP_CYCLES = 5,
    parameter int ZERO_TICKS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic zero_i,
    input  logic tick_i,
    output logic clr_o
);
    localparam int SW = $clog2(STOP_CYCLES + 1);
    localparam int ZW = $clog2(ZERO_TICKS + 1);

    typedef struct packed {
        logic [SW-1:0] stop_cnt;
        logic [ZW-1:0] zero_cnt;
    } clr_st_t;

    clr_st_t st_q, st_d;
    logic stop_hit, zero_sat, zero_hit;

    always_comb begin
        st_d     = st_q;
        stop_hit = stop_i && (st_q.stop_cnt == SW'(STOP_CYCLES - 1));
        zero_sat = (st_q.zero_cnt == ZW'(ZERO_TICKS - 1));
        zero_hit = zero_i && tick_i && zero_sat;
        if (!stop_i)       st_d.stop_cnt = '0;
        else if (!stop_hit) st_d.stop_cnt = st_q.stop_cnt + 1'b1;
        if (!zero_i)                  st_d.zero_cnt = '0;
        else if (tick_i && !zero_sat) st_d.zero_cnt = st_q.zero_cnt + 1'b1;
        clr_o = stop_hit || zero_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && !zero_i) |-> !clr_o); // R7

endmodule

// File: rtl/rrp_rev_timer.sv
module rrp_rev_timer #(
    parameter int BACK_LIMIT = 3,
    parameter int LOCK_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic fwd_i,
    input  logic back_i,
    input  logic drive_i,
    input  logic tick_i,
    output logic rev_o,
    output logic latch_o
);
    localparam int BW = $clog2(BACK_LIMIT + 1);
    localparam int TW = $clog2(LOCK_TICKS + 1);

    typedef struct packed {
        logic [BW-1:0] back;
        logic [TW-1:0] timer;
        logic          kill;
    } rt_st_t;

    rt_st_t st_q, st_d;
    logic   reversing;

    always_comb begin
        st_d      = st_q;
        reversing = (st_q.back == BW'(BACK_LIMIT));
        if (clr_i) begin
            st_d = '0;
        end else if (fwd_i) begin
            st_d.back  = '0;
            st_d.timer = '0;
        end else begin
            if (back_i && !reversing) st_d.back = st_q.back + 1'b1;
            if (reversing && drive_i) begin
                if (tick_i) begin
                    if (st_q.timer == TW'(LOCK_TICKS - 1)) begin
                        st_d.kill  = 1'b1;
                        st_d.timer = '0;
                    end else begin
                        st_d.timer = st_q.timer + 1'b1;
                    end
                end
            end else begin
                st_d.timer = '0;
            end
        end
        rev_o   = reversing;
        latch_o = st_q.kill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FWD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_i |=> (st_q.back == '0)); // R9

    AST_LATCH_NEEDS_REV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.kill) |-> ($past(reversing) && $past(drive_i))); // R4

    AST_CLR_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !st_q.kill); // R7

endmodule

// File: rtl/reverse_guard.sv
module reverse_guard #(
    parameter int BACK_LIMIT  = 3,
    parameter int LOCK_TICKS  = 8,
    parameter int ZERO_TICKS  = 4,
    parameter int STOP_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_i,
    input  logic       prot_sel_n,
    input  logic       drive_on_i,
    input  logic       zero_duty_i,
    input  logic       stop_i,
    input  logic       tick_i,
    output logic       rev_o,
    output logic       kill_o
);
    logic fwd_step, back_step;
    logic clr_evt, clr_all;
    logic reversing, latched;

    rrp_hall_judge u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .hall_i (hall_i),
        .dir_i  (dir_i),
        .fwd_o  (fwd_step),
        .back_o (back_step)
    );

    rrp_clear_ctl #(
        .STOP_CYCLES (STOP_CYCLES),
        .ZERO_TICKS  (ZERO_TICKS)
    ) u_clear (
        .clk    (clk),
        .rst_n  (rst_n),
        .stop_i (stop_i),
        .zero_i (zero_duty_i),
        .tick_i (tick_i),
        .clr_o  (clr_evt)
    );

    assign clr_all = clr_evt || prot_sel_n;

    rrp_rev_timer #(
        .BACK_LIMIT (BACK_LIMIT),
        .LOCK_TICKS (LOCK_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_all),
        .fwd_i   (fwd_step),
        .back_i  (back_step),
        .drive_i (drive_on_i),
        .tick_i  (tick_i),
        .rev_o   (reversing),
        .latch_o (latched)
    );

    always_comb begin
        rev_o  = !prot_sel_n && reversing;
        kill_o = !prot_sel_n && (latched || zero_duty_i);
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        prot_sel_n |=> (!latched && !reversing)); // R1

endmodule

// File: tb/tb_reverse_guard.sv
module tb_reverse_guard;
    localparam int LOCK = 8;
    localparam int ZT   = 4;
    localparam int STOP = 5;
    localparam int LIM  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] hall = 3'b101;
    logic dir = 1'b0, sel_n = 1'b0, drive = 1'b0, zero = 1'b0, stop = 1'b0, tick = 1'b0;
    logic rev_o, kill_o;

    int n_run = 0, n_fail = 0, cyc = 0, pos = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_last, m_back, m_timer, m_kill, m_stop, m_zero;

    always #5 clk = ~clk;

    reverse_guard #(.BACK_LIMIT(LIM), .LOCK_TICKS(LOCK), .ZERO_TICKS(ZT), .STOP_CYCLES(STOP)) dut (
        .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_i(dir), .prot_sel_n(sel_n),
        .drive_on_i(drive), .zero_duty_i(zero), .stop_i(stop), .tick_i(tick),
        .rev_o(rev_o), .kill_o(kill_o));

    function automatic int step_of(input logic [2:0] h);
        case (h)
            3'b101: return 0;  3'b100: return 1;  3'b110: return 2;
            3'b010: return 3;  3'b011: return 4;  3'b001: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic logic [2:0] code_of(input int i);
        case (i)
            0: return 3'b101; 1: return 3'b100; 2: return 3'b110;
            3: return 3'b010; 4: return 3'b011; default: return 3'b001;
        endcase
    endfunction

    // time-base strobe: one cycle in four
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 tick = ((cyc % 4) == 0);
    end

    // reference model, updated each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_last = -1; m_back = 0; m_timer = 0; m_kill = 0; m_stop = 0; m_zero = 0;
        end else begin
            int s; bit fwd, bk, clr, revg;
            s = step_of(hall); fwd = 0; bk = 0;
            if (s >= 0 && m_last >= 0 && s != m_last) begin
                if (dir == 1'b0) begin
                    fwd = (s == (m_last + 1) % 6); bk = (s == (m_last + 5) % 6);
                end else begin
                    fwd = (s == (m_last + 5) % 6); bk = (s == (m_last + 1) % 6);
                end
            end
            if (s >= 0) m_last = s;
            clr = sel_n || (stop && m_stop == STOP - 1) || (zero && tick && m_zero == ZT - 1);
            if (!stop) m_stop = 0; else if (m_stop < STOP - 1) m_stop++;
            if (!zero) m_zero = 0; else if (tick && m_zero < ZT - 1) m_zero++;
            revg = (m_back == LIM);
            if (clr) begin
                m_back = 0; m_timer = 0; m_kill = 0;
            end else if (fwd) begin
                m_back = 0; m_timer = 0;
            end else begin
                if (bk && !revg) m_back++;
                if (revg && drive) begin
                    if (tick) begin
                        if (m_timer == LOCK - 1) begin m_kill = 1; m_timer = 0; end
                        else m_timer++;
                    end
                end else m_timer = 0;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic ek, er;
            er = !sel_n && (m_back == LIM);
            ek = !sel_n && (m_kill != 0 || zero);
            n_run++;
            if (rev_o !== er || kill_o !== ek) begin
                n_fail++;
                $display("FAIL %s cycle %0d: rev=%b kill=%b expected rev=%b kill=%b",
                         cur_req, cyc, rev_o, kill_o, er, ek);
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // move the rotor d positions (+1 index up, -1 index down)
    task automatic move(input int d, input int n);
        for (int k = 0; k < n; k++) begin
            pos = (pos + 6 + d) % 6;
            hall = code_of(pos);
            waitc(2);
        end
    endtask

    task automatic do_stop(input int n);
        stop = 1'b1; waitc(n); stop = 1'b0; waitc(2);
    endtask

    initial begin
        waitc(3);
        rst_n = 1'b1;
        waitc(2);
        cur_req = "R1";
        check(kill_o, 1'b0, "R1", "reset kill");
        check(rev_o, 1'b0, "R1", "reset rev");

        // disabled: backward travel and drive do nothing
        sel_n = 1'b1; drive = 1'b1;
        move(-1, 5); waitc(4 * LOCK + 8); zero = 1'b1; waitc(2);
        check(kill_o, 1'b0, "R1", "disabled kill");
        check(rev_o, 1'b0, "R1", "disabled rev");
        zero = 1'b0; drive = 1'b0; sel_n = 1'b0; waitc(2);

        // forward rotation, dir low
        cur_req = "R2";
        move(1, 8);
        check(rev_o, 1'b0, "R2", "forward dir0 no reversal");

        // three backward steps
        cur_req = "R3";
        move(-1, 2);
        check(rev_o, 1'b0, "R3", "two back steps");
        move(-1, 1);
        check(rev_o, 1'b1, "R3", "third back step");

        // lock period while driven
        cur_req = "R4";
        drive = 1'b1;
        waitc(4 * (LOCK - 2));
        check(kill_o, 1'b0, "R4", "before lock period");
        waitc(4 * 3);
        check(kill_o, 1'b1, "R4", "after lock period");

        // short stop keeps latch, long stop clears
        cur_req = "R7";
        drive = 1'b0;
        do_stop(STOP - 2);
        check(kill_o, 1'b1, "R7", "short stop");
        do_stop(STOP + 1);
        check(kill_o, 1'b0, "R7", "long stop");
        check(rev_o, 1'b0, "R7", "long stop rev");

        // forward step cancels pending reversal
        cur_req = "R9";
        move(-1, 3); drive = 1'b1;
        waitc(4 * (LOCK / 2));
        move(1, 1);
        check(rev_o, 1'b0, "R9", "forward resets count");
        move(-1, 3);
        waitc(4 * (LOCK - 2));
        check(kill_o, 1'b0, "R9", "timer restarted");
        waitc(4 * 4);
        check(kill_o, 1'b1, "R9", "latched after full period");

        // zero duty: forces kill, long hold clears latch
        cur_req = "R8";
        zero = 1'b1; waitc(4);
        zero = 1'b0; waitc(2);
        check(kill_o, 1'b1, "R8", "short zero keeps latch");
        zero = 1'b1; waitc(4 * ZT + 8);
        check(kill_o, 1'b1, "R6", "zero forces kill");
        zero = 1'b0; waitc(2);
        check(kill_o, 1'b0, "R8", "long zero cleared latch");
        drive = 1'b0;
        cur_req = "R6";
        zero = 1'b1; waitc(1);
        check(kill_o, 1'b1, "R6", "zero with no latch");
        zero = 1'b0; waitc(2);

        // invalid codes ignored
        cur_req = "R10";
        move(1, 1);
        move(-1, 2);
        hall = 3'b000; waitc(2);
        hall = 3'b111; waitc(2);
        check(rev_o, 1'b0, "R10", "invalid codes no count");
        move(-1, 1);
        check(rev_o, 1'b1, "R10", "count survived invalid codes");
        do_stop(STOP);

        // direction high: index down is forward
        cur_req = "R2";
        dir = 1'b1; waitc(2);
        move(-1, 7);
        check(rev_o, 1'b0, "R2", "forward dir1");
        move(1, 3);
        check(rev_o, 1'b1, "R2", "backward dir1");
        move(-1, 1);

        // reversing before drive: grace period starts at drive on
        cur_req = "R5";
        move(1, 3);
        waitc(4 * LOCK + 12);
        check(kill_o, 1'b0, "R5", "no latch while undriven");
        drive = 1'b1;
        waitc(4 * (LOCK - 2));
        check(kill_o, 1'b0, "R5", "grace after drive start");
        waitc(4 * 3);
        check(kill_o, 1'b1, "R5", "latched after grace");

        // disabling clears
        cur_req = "R1";
        sel_n = 1'b1; waitc(2);
        sel_n = 1'b0; waitc(2);
        check(kill_o, 1'b0, "R1", "disable cleared latch");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(1_500_000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule